// File: doc/BRIEF.md
# Channel Selection and Chaining Detector

This block sits at the control-unit end of a parallel I/O channel. It decides quickly whether the channel is trying to select this unit. The channel can do this in two ways. It can address the unit directly, with an address on the outbound data bus while address-out is up. It can also answer a request that the unit raised earlier, in which case address-out stays down. When an attempt does not select this unit, the block passes the selection on to the next unit. Select-out and hold-out are each sampled on two clock edges before an attempt is recognised, so a short glitch on either line never selects or propagates.

Software loads a unit address and a mask ahead of time. Only the bus bits with a 1 in the mask are compared, so one mask value covers a whole group of device addresses. The unit has two request sources. One is always passed to request-in. The other is dropped while suppress-out is up. The block also flags command chaining. The chaining flag is set when service-out rises with suppress-out up while the unit is presenting ending status. It is cleared only after suppress-out has stayed low for a minimum time, which is converted to a count of clock cycles.

Top module: `chan_sel_detect`

## Requirements
- R1: The address match is true exactly when, for every bit position i with `addr_mask[i]`=1, `bus_out[i]` equals `unit_addr[i]`. Bits whose mask bit is 0 are not compared. Example: with mask 0xF0, only bits 7..4 are compared.
- R2: A selection attempt counts as present only when `sel_out` and `hold_out` were both sampled high at each of the last two rising clock edges. When no attempt is present, `sel` and `sel_prop` are both 0.
- R3: While an attempt is present and `addr_out` is 1, `sel` equals the R1 address match, with no added delay.
- R4: `req_in` equals `req_ns` OR (`req_sup` AND NOT `sup_out`), with no added delay.
- R5: While an attempt is present and `addr_out` is 0, `sel` equals `req_in`. While `addr_out` is 1, the request sources have no effect on `sel`.
- R6: `sel_prop` is 1 exactly when an attempt is present and `sel` is 0.
- R7: `chain` becomes 1 after a rising edge at which `srv_out`, `sup_out` and `stat_end` are all sampled 1 and `srv_out` was sampled 0 at the edge before. A rise of `srv_out` while `stat_end` or `sup_out` is 0 does not set it.
- R8: `chain` returns to 0 after the rising edge at which `sup_out` has been sampled low on DROP_CYC consecutive edges. DROP_CYC is MIN_DROP_NS/CLK_NS rounded up, which is 13 at the defaults. A shorter low stretch leaves `chain` at 1.
- R9: While `rst_n` is sampled low, `chain` and the deglitch history are cleared, so `chain`, `sel` and `sel_prop` read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_out | input | BUS_W | Outbound channel data bus |
| unit_addr | input | BUS_W | Loaded unit address |
| addr_mask | input | BUS_W | Loaded compare mask, 1 = compare bit |
| sel_out | input | 1 | Select-out tag |
| hold_out | input | 1 | Hold-out tag |
| addr_out | input | 1 | Address-out tag |
| sup_out | input | 1 | Suppress-out tag |
| srv_out | input | 1 | Service-out tag |
| stat_end | input | 1 | Unit is presenting channel-end or device-end status |
| req_ns | input | 1 | Non-suppressible request source |
| req_sup | input | 1 | Suppressible request source |
| sel | output | 1 | Unit selected |
| req_in | output | 1 | Request-in to the channel |
| chain | output | 1 | Command chaining detected |
| sel_prop | output | 1 | Select propagated to the next unit |

## Verification
The hardest case to reach is the clearing of `chain`. The bench must first raise service-out while suppress-out and ending status are both up. It then has to hold suppress-out low for exactly the filter length, after first breaking an earlier low stretch one cycle short so that the counter is seen to restart. The stimulus drives these stretches with directed sequences of fixed length. It also sends one-cycle select pulses to show that the deglitch filter rejects them. A long biased random phase then mixes address, request and tag patterns, and a behavioural model is compared on every clock.

// File: rtl/chsel_pkg.sv
// Shared helpers for the channel selection detector.
// Assumes: time values are given in whole nanoseconds.
package chsel_pkg;

    // Convert a minimum duration into a cycle count, rounding up.
    function automatic int ns_to_cycles(input int dur_ns, input int period_ns);
        return (dur_ns + period_ns - 1) / period_ns;
    endfunction

    // Bundle of channel tag-out lines used inside the block.
    typedef struct packed {
        logic sel;
        logic hold;
        logic addr;
        logic sup;
        logic srv;
    } tag_out_t;

endpackage

// File: rtl/chsel_addr_match.sv
// Masked unit-address comparator.
// Does: reports a hit when every bus bit selected by the mask equals the
//       loaded unit address bit. Assumes: mask and address are stable
//       registers loaded in advance.
module chsel_addr_match #(
    parameter int BUS_W = 8
) (
    input  logic [BUS_W-1:0] bus_val,
    input  logic [BUS_W-1:0] ref_addr,
    input  logic [BUS_W-1:0] cmp_mask,
    output logic             hit
);

    logic [BUS_W-1:0] bit_ok;

    // Per-bit compare: a masked-off bit always counts as matching.
    for (genvar i = 0; i < BUS_W; i++) begin : g_bit
        assign bit_ok[i] = ~cmp_mask[i] | ~(bus_val[i] ^ ref_addr[i]);
    end

    // Hit when all positions agree.
    always_comb hit = &bit_ok;

endmodule

// File: rtl/chsel_deglitch.sv
// Two-sample qualifier for the select/hold attempt.
// Does: shifts the raw select-and-hold level through two flops; the attempt
//       is recognised only when both samples are high. Assumes: raw inputs
//       are synchronous to clk.
module chsel_deglitch (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_in,
    output logic attempt
);

    logic [1:0] hist;

    // Shift history of the raw attempt level.
    always_ff @(posedge clk) begin
        if (!rst_n) hist <= '0;
        else        hist <= {hist[0], raw_in};
    end

    // Attempt needs two consecutive high samples.
    always_comb attempt = &hist;

    // R2
    two_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
        attempt |-> ($past(raw_in) && $past(raw_in, 2)));

endmodule

// File: rtl/chsel_chain_det.sv
// Command chaining detector with a minimum-drop filter on suppress-out.
// Does: sets the flag when service-out rises with suppress-out high during
//       ending status; clears it once suppress-out has been low for DROP_CYC
//       consecutive samples. Assumes: DROP_CYC >= 1.
module chsel_chain_det #(
    parameter int DROP_CYC = 13
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sup_in,
    input  logic srv_in,
    input  logic stat_end,
    output logic chain
);

    localparam int CW = $clog2(DROP_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(DROP_CYC - 1);
    localparam logic [CW-1:0] FULL = CW'(DROP_CYC);

    logic          srv_d;
    logic [CW-1:0] low_cnt;
    logic          srv_rise;
    logic          set_c;
    logic          clr_c;

    // Edge detect on service-out and set/clear conditions.
    always_comb begin
        srv_rise = srv_in & ~srv_d;
        set_c    = srv_rise & sup_in & stat_end;
        clr_c    = ~sup_in & (low_cnt == LAST);
    end

    // Remember last service-out sample.
    always_ff @(posedge clk) begin
        if (!rst_n) srv_d <= 1'b0;
        else        srv_d <= srv_in;
    end

    // Count consecutive low samples of suppress-out, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n)            low_cnt <= '0;
        else if (sup_in)       low_cnt <= '0;
        else if (low_cnt != FULL) low_cnt <= low_cnt + 1'b1;
    end

    // Chaining flag.
    always_ff @(posedge clk) begin
        if (!rst_n)     chain <= 1'b0;
        else if (set_c) chain <= 1'b1;
        else if (clr_c) chain <= 1'b0;
    end

    // R7
    chain_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(chain) |-> $past(sup_in && stat_end && srv_in));

    // R8
    chain_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(chain) |-> !$past(sup_in));

    // R8
    drop_cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        low_cnt <= FULL);

endmodule

// File: rtl/chan_sel_detect.sv
// Channel selection and chaining detector, top level.
// Does: combines the deglitched select/hold attempt with the masked address
//       match (address-out up) or the request-in level (address-out down)
//       into SEL, propagates unsuccessful attempts, builds request-in and
//       detects command chaining. Assumes: all inputs synchronous to clk.
module chan_sel_detect #(
    parameter int BUS_W       = 8,
    parameter int CLK_NS      = 20,
    parameter int MIN_DROP_NS = 250
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [BUS_W-1:0] bus_out,
    input  logic [BUS_W-1:0] unit_addr,
    input  logic [BUS_W-1:0] addr_mask,
    input  logic             sel_out,
    input  logic             hold_out,
    input  logic             addr_out,
    input  logic             sup_out,
    input  logic             srv_out,
    input  logic             stat_end,
    input  logic             req_ns,
    input  logic             req_sup,
    output logic             sel,
    output logic             req_in,
    output logic             chain,
    output logic             sel_prop
);

    import chsel_pkg::*;

    localparam int DROP_CYC = ns_to_cycles(MIN_DROP_NS, CLK_NS);

    tag_out_t tags;
    logic     addr_hit;
    logic     attempt;

    // Bundle tag inputs.
    always_comb tags = '{sel: sel_out, hold: hold_out, addr: addr_out,
                         sup: sup_out, srv: srv_out};

    chsel_addr_match #(.BUS_W(BUS_W)) u_match (
        .bus_val  (bus_out),
        .ref_addr (unit_addr),
        .cmp_mask (addr_mask),
        .hit      (addr_hit)
    );

    chsel_deglitch u_dgl (
        .clk     (clk),
        .rst_n   (rst_n),
        .raw_in  (tags.sel & tags.hold),
        .attempt (attempt)
    );

    chsel_chain_det #(.DROP_CYC(DROP_CYC)) u_chain (
        .clk      (clk),
        .rst_n    (rst_n),
        .sup_in   (tags.sup),
        .srv_in   (tags.srv),
        .stat_end (stat_end),
        .chain    (chain)
    );

    // Request-in: suppressible source masked by suppress-out.
    always_comb req_in = req_ns | (req_sup & ~tags.sup);

    // Selection decision and propagation of unsuccessful attempts.
    always_comb begin
        sel      = attempt & (tags.addr ? addr_hit : req_in);
        sel_prop = attempt & ~sel;
    end

    // R3
    addr_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && addr_out) |-> addr_hit);

    // R4
    sup_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sup_out && !req_ns) |-> !req_in);

    // R6
    prop_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_out && hold_out && $past(sel_out && hold_out)) |=> (sel || sel_prop));

endmodule

// File: tb/chan_sel_detect_tb.sv
module chan_sel_detect_tb;

    localparam int W = 8;
    localparam int DROP = 13;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [W-1:0] bus_out = '0, unit_addr = '0, addr_mask = '0;
    logic sel_out = 0, hold_out = 0, addr_out = 0, sup_out = 0, srv_out = 0;
    logic stat_end = 0, req_ns = 0, req_sup = 0;
    logic sel, req_in, chain, sel_prop;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    chan_sel_detect u_dut (
        .clk(clk), .rst_n(rst_n), .bus_out(bus_out), .unit_addr(unit_addr),
        .addr_mask(addr_mask), .sel_out(sel_out), .hold_out(hold_out),
        .addr_out(addr_out), .sup_out(sup_out), .srv_out(srv_out),
        .stat_end(stat_end), .req_ns(req_ns), .req_sup(req_sup),
        .sel(sel), .req_in(req_in), .chain(chain), .sel_prop(sel_prop)
    );

    // Behavioural reference state
    bit m_s0 = 0, m_s1 = 0, m_srv = 0, m_chain = 0;
    int m_low = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_s0 = 0; m_s1 = 0; m_srv = 0; m_chain = 0; m_low = 0;
        end else begin
            bit rise;
            rise = srv_out && !m_srv;
            m_low = sup_out ? 0 : m_low + 1;
            if (rise && sup_out && stat_end) m_chain = 1;
            else if (m_low == DROP) m_chain = 0;
            m_srv = srv_out;
            m_s1 = m_s0;
            m_s0 = sel_out && hold_out;
        end
    end

    task automatic check(input string req, input logic act, input logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    // Compare every clock, on the falling edge
    always @(negedge clk) begin
        bit att, match, rq, se;
        match = (((bus_out ^ unit_addr) & addr_mask) == '0);      // R1
        rq    = req_ns || (req_sup && !sup_out);
        att   = m_s0 && m_s1;                                     // R2
        se    = att && (addr_out ? match : rq);
        if (!rst_n) begin
            check("R9 chain in reset", chain, 1'b0);
        end
        check("R1 R2 R3 R5 sel", sel, se);
        check("R4 req_in", req_in, rq);
        check("R6 sel_prop", sel_prop, att && !se);
        check("R7 R8 chain", chain, m_chain);
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic attempt_on(input bit a);
        sel_out = 1; hold_out = 1; addr_out = a;
    endtask

    initial begin
        fork
            begin
                #1;
                step(3);
                rst_n = 1;
                // R1 R3: mask F0, unit A0 group
                addr_mask = 8'hF0; unit_addr = 8'hA0; bus_out = 8'hA7;
                attempt_on(1); step(4);
                check("R3 hit sel", sel, 1'b1);
                bus_out = 8'hB7; step(1);
                check("R6 miss propagates", sel_prop, 1'b1);
                // R1: full mask exact compare
                addr_mask = 8'hFF; unit_addr = 8'h3C; bus_out = 8'h3C; step(1);
                bus_out = 8'h3D; step(1);
                addr_mask = 8'h00; step(1);
                sel_out = 0; hold_out = 0; step(3);
                // R2: one-cycle glitch does not select
                bus_out = 8'h3C; addr_mask = 8'hFF;
                attempt_on(1); step(1); sel_out = 0; step(1);
                check("R2 glitch no sel", sel, 1'b0);
                hold_out = 0; step(2);
                // R5: request reply paths
                req_sup = 1; sup_out = 0; attempt_on(0); step(3);
                check("R5 reply sel", sel, 1'b1);
                sup_out = 1; step(1);
                check("R4 suppressed", req_in, 1'b0);
                req_ns = 1; step(1);
                addr_out = 1; bus_out = 8'h00; step(1);
                check("R5 addr_out blocks request", sel, 1'b0);
                sel_out = 0; hold_out = 0; req_ns = 0; req_sup = 0; step(3);
                // R7: rise without status does not set
                sup_out = 1; stat_end = 0; srv_out = 1; step(2);
                check("R7 no status no chain", chain, 1'b0);
                srv_out = 0; step(1);
                stat_end = 1; srv_out = 1; step(1);
                check("R7 chain set", chain, 1'b1);
                srv_out = 0; stat_end = 0;
                // R8: short drop keeps chain
                sup_out = 0; step(DROP - 1);
                sup_out = 1; step(1);
                check("R8 short drop keeps", chain, 1'b1);
                sup_out = 0; step(DROP - 1);
                check("R8 before limit", chain, 1'b1);
                step(1);
                check("R8 cleared", chain, 1'b0);
                // Mid-run reset
                sup_out = 1; srv_out = 1; stat_end = 1; step(2);
                rst_n = 0; step(2);
                check("R9 reset chain", chain, 1'b0);
                rst_n = 1; srv_out = 0; stat_end = 0; step(1);
                // Random mix
                for (int i = 0; i < 4000; i++) begin
                    bus_out   = ($urandom % 2) ? 8'h3C : W'($urandom);
                    addr_mask = ($urandom % 2) ? 8'hFF : 8'hF0;
                    unit_addr = 8'h3C;
                    if ($urandom % 4 == 0) sel_out = $urandom;
                    if ($urandom % 4 == 0) hold_out = $urandom;
                    addr_out = ($urandom % 3 != 0);
                    if ($urandom % 6 == 0) sup_out = ~sup_out;
                    srv_out = ($urandom % 3 == 0);
                    stat_end = $urandom; req_ns = ($urandom % 4 == 0);
                    req_sup = $urandom;
                    if ($urandom % 200 == 0) begin
                        sup_out = 0; step(DROP + 2);
                    end
                    step(1);
                end
            end
            begin
                repeat (150000) @(posedge clk);
                n_cmp++; n_bad++;
                $display("FAIL watchdog actual=running expected=finished");
            end
        join_any
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule